// File: doc/BRIEF.md
# Physical Memory Protection Checker

This block guards a 34-bit physical address space for a processor core. It holds a bank of protection entries. Each entry has a configuration byte and an address register, and both are reached through a plain control-register port that takes a register number, a write enable and write data, and returns read data. Four configuration bytes share one 32-bit control register. Each address register stores a byte address shifted right by two.

A separate check port takes one access at a time. The access carries a physical address, a kind (instruction fetch, data load or data store) and a flag that is high for machine mode. The port returns allow or deny and, on deny, the fault cause code the core should raise. The decision logic is combinational. Each entry can cover a top-of-range span, a single four-byte word, or a naturally aligned power-of-two region. When several entries cover the address, the lowest-numbered one decides.

A lock bit freezes an entry's settings until reset. It also makes the entry's permissions apply to machine mode. The core supplies the register number and the access; instruction decode and trap entry live elsewhere.

Top module: `pmp_unit`

## Requirements
- R1: After reset every configuration byte and address register reads zero, every entry is off and unlocked, and no lock is left from before the reset.
- R2: Entry n's configuration byte sits in bits 8*(n%4)+7 down to 8*(n%4) of register 0x3A0+n/4. In that byte, bit 0 grants read, bit 1 grants write, bit 2 grants execute, bits 4:3 choose the mode and bit 7 locks the entry. Bits 6:5 always read as zero.
- R3: Entry n's address register is register 0x3B0+n and holds bits 33:2 of a byte address. A write to it reads back unchanged while the entry is writable.
- R4: Mode 01 (top of range) matches byte addresses A with prev*4 <= A < own*4. Here "own" is the entry's address register and "prev" is the previous entry's address register, or zero for entry 0.
- R5: Mode 10 covers exactly the four bytes that start at the entry's address register times four.
- R6: Mode 11 (power-of-two region) first appends two one bits below the stored value, giving v. The region then runs from v AND (v+1) up to v OR (v+1), inclusive. Mode 00 matches nothing.
- R7: When several entries match, only the lowest-numbered matching entry decides the access.
- R8: When no entry matches, a machine-mode access is allowed and any lower-privilege access is denied.
- R9: A matching entry allows the access if the permission bit for the access kind is set. A machine-mode access matching an unlocked entry is always allowed. A machine-mode access matching a locked entry follows that entry's permission bits.
- R10: While an entry's lock bit is set, writes to its configuration byte and to its address register have no effect. Other bytes in the same configuration register still take the write.
- R11: While entry n+1 is locked and in top-of-range mode, writes to entry n's address register have no effect.
- R12: Entries 8 to 15 are hardwired to zero. Their configuration bytes and address registers read zero and ignore writes. Register numbers outside both register ranges read zero.
- R13: Access kind is encoded 00 for fetch, 01 for load and 10 for store. A denied fetch reports cause 1, a denied load cause 5 and a denied store cause 7. An allowed access reports cause 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| csr_num | input | 12 | Control register number |
| csr_we | input | 1 | Write enable for the addressed register |
| csr_wdata | input | 32 | Write data |
| csr_rdata | output | 32 | Read data of the addressed register (combinational) |
| chk_addr | input | 34 | Physical byte address of the access |
| chk_kind | input | 2 | Access kind: 00 fetch, 01 load, 10 store |
| chk_mmode | input | 1 | High for a machine-mode access |
| chk_allow | output | 1 | High when the access is permitted |
| chk_cause | output | 4 | Fault cause when denied, zero when allowed |

## Verification
The assertions assume that reset is asserted for at least one clock edge before any check is sampled. They also assume that the access kind never takes the reserved value 11. The assertions check the fault cause against the kind on every cycle, the frozen state of locked entries, and the default decision when every entry is off. Every access the stimulus drives uses one of the three defined kinds. Register writes come only on whole cycles between falling edges, so each write lands on exactly one rising edge.

// File: rtl/pmp_pkg.sv
// Package: shared types and constants for the protection unit.
// Assumes a 32-bit control-register data path and 34-bit physical addresses.
package pmp_pkg;

    localparam int XLEN    = 32;
    localparam int PA_W    = 34;
    localparam int CAUSE_W = 4;

    localparam logic [11:0] CSR_CFG_BASE  = 12'h3A0;
    localparam logic [11:0] CSR_ADDR_BASE = 12'h3B0;

    localparam logic [CAUSE_W-1:0] CAUSE_NONE  = 4'd0;
    localparam logic [CAUSE_W-1:0] CAUSE_FETCH = 4'd1;
    localparam logic [CAUSE_W-1:0] CAUSE_LOAD  = 4'd5;
    localparam logic [CAUSE_W-1:0] CAUSE_STORE = 4'd7;

    typedef enum logic [1:0] {
        AM_OFF   = 2'b00,
        AM_TOR   = 2'b01,
        AM_NA4   = 2'b10,
        AM_NAPOT = 2'b11
    } amode_e;

    typedef enum logic [1:0] {
        ACC_FETCH = 2'b00,
        ACC_LOAD  = 2'b01,
        ACC_STORE = 2'b10
    } acc_e;

    typedef struct packed {
        logic       lock;
        logic [1:0] rsv;
        amode_e     mode;
        logic       x;
        logic       w;
        logic       r;
    } cfg_t;

    // Turn a raw written byte into a legal configuration value
    function automatic cfg_t legalize(input logic [7:0] raw);
        cfg_t c;
        c     = cfg_t'(raw);
        c.rsv = 2'b00;
        return c;
    endfunction

endpackage

// File: rtl/pmp_regs.sv
// Module: register bank for the protection entries.
// Holds the configuration bytes and address registers and applies the lock
// rules on writes. Entries at or above NUM_ACTIVE are constant zero.
// Assumes NUM_ENTRIES is a multiple of four and NUM_ACTIVE <= NUM_ENTRIES.
module pmp_regs
    import pmp_pkg::*;
#(
    parameter int NUM_ENTRIES = 16,
    parameter int NUM_ACTIVE  = 8,
    parameter int AW          = 32
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [11:0]                      csr_num,
    input  logic                             csr_we,
    input  logic [XLEN-1:0]                  csr_wdata,
    output logic [XLEN-1:0]                  csr_rdata,
    output cfg_t [NUM_ENTRIES-1:0]           cfg_o,
    output logic [NUM_ENTRIES-1:0][AW-1:0]   addr_o
);

    localparam int NCFG_REGS = NUM_ENTRIES / 4;

    cfg_t [NUM_ENTRIES-1:0]         cfg_q;
    logic [NUM_ENTRIES-1:0][AW-1:0] addr_q;

    logic [11:0]            cfg_off;
    logic [11:0]            addr_off;
    logic                   cfg_hit;
    logic                   addr_hit;
    logic [NUM_ENTRIES-1:0] cfg_wr;
    logic [NUM_ENTRIES-1:0] addr_wr;
    logic [NUM_ENTRIES-1:0] addr_lock;

    // Decode which register range the register number falls into
    always_comb begin
        cfg_off  = csr_num - CSR_CFG_BASE;
        addr_off = csr_num - CSR_ADDR_BASE;
        cfg_hit  = cfg_off < 12'(NCFG_REGS);
        addr_hit = addr_off < 12'(NUM_ENTRIES);
    end

    // Work out which address registers are frozen by a lock
    always_comb begin
        for (int n = 0; n < NUM_ENTRIES; n++) begin
            addr_lock[n] = cfg_q[n].lock;
        end
        for (int n = 0; n < NUM_ENTRIES - 1; n++) begin
            if (cfg_q[n+1].lock && (cfg_q[n+1].mode == AM_TOR)) begin
                addr_lock[n] = 1'b1;
            end
        end
    end

    // Per-entry write enables after range, lock and hardwiring checks
    always_comb begin
        for (int n = 0; n < NUM_ENTRIES; n++) begin
            cfg_wr[n]  = csr_we && cfg_hit && (cfg_off == 12'(n / 4))
                         && !cfg_q[n].lock && (n < NUM_ACTIVE);
            addr_wr[n] = csr_we && addr_hit && (addr_off == 12'(n))
                         && !addr_lock[n] && (n < NUM_ACTIVE);
        end
    end

    // Configuration byte storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            for (int n = 0; n < NUM_ENTRIES; n++) begin
                if (cfg_wr[n]) begin
                    cfg_q[n] <= legalize(csr_wdata[8*(n%4) +: 8]);
                end
            end
        end
    end

    // Address register storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else begin
            for (int n = 0; n < NUM_ENTRIES; n++) begin
                if (addr_wr[n]) begin
                    addr_q[n] <= csr_wdata[AW-1:0];
                end
            end
        end
    end

    // Read multiplexer; unknown numbers read zero
    always_comb begin
        csr_rdata = '0;
        if (cfg_hit) begin
            for (int k = 0; k < NCFG_REGS; k++) begin
                if (cfg_off == 12'(k)) begin
                    for (int b = 0; b < 4; b++) begin
                        csr_rdata[8*b +: 8] = cfg_q[4*k+b];
                    end
                end
            end
        end else if (addr_hit) begin
            for (int n = 0; n < NUM_ENTRIES; n++) begin
                if (addr_off == 12'(n)) begin
                    csr_rdata = XLEN'(addr_q[n]);
                end
            end
        end
    end

    assign cfg_o  = cfg_q;
    assign addr_o = addr_q;

endmodule

// File: rtl/pmp_match.sv
// Module: region matcher for one entry.
// Decides whether a byte address falls inside the entry's region for the
// selected mode. Purely combinational; assumes AW = PA_W - 2.
module pmp_match
    import pmp_pkg::*;
#(
    parameter int AW = 32
) (
    input  amode_e          mode,
    input  logic [AW-1:0]   addr_cur,
    input  logic [AW-1:0]   addr_prev,
    input  logic [AW+1:0]   chk_addr,
    output logic            hit
);

    logic [AW-1:0] word;
    logic [AW+1:0] v;
    logic [AW+1:0] v_inc;
    logic [AW+1:0] napot_lo;
    logic [AW+1:0] napot_hi;

    // Derive the word index and the power-of-two region bounds
    always_comb begin
        word     = chk_addr[AW+1:2];
        v        = {addr_cur, 2'b11};
        v_inc    = v + 1'b1;
        napot_lo = v & v_inc;
        napot_hi = v | v_inc;
    end

    // Select the compare for the configured mode
    always_comb begin
        unique case (mode)
            AM_TOR:   hit = (word >= addr_prev) && (word < addr_cur);
            AM_NA4:   hit = (word == addr_cur);
            AM_NAPOT: hit = (chk_addr >= napot_lo) && (chk_addr <= napot_hi);
            default:  hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/pmp_select.sv
// Module: priority selector and permission decision.
// Picks the lowest-numbered matching entry and applies its permissions,
// honouring the lock bit for machine mode. The reserved kind is treated as a store.
module pmp_select
    import pmp_pkg::*;
#(
    parameter int NUM_ENTRIES = 16
) (
    input  logic [NUM_ENTRIES-1:0] hits,
    input  cfg_t [NUM_ENTRIES-1:0] cfg,
    input  logic [1:0]             kind,
    input  logic                   mmode,
    output logic                   allow,
    output logic [CAUSE_W-1:0]     cause
);

    logic found;
    cfg_t win;
    logic perm;

    // Find the first matching entry in index order
    always_comb begin
        found = 1'b0;
        win   = '0;
        for (int n = 0; n < NUM_ENTRIES; n++) begin
            if (!found && hits[n]) begin
                found = 1'b1;
                win   = cfg[n];
            end
        end
    end

    // Apply the winning permissions and form the fault cause
    always_comb begin
        unique case (kind)
            ACC_FETCH: perm = win.x;
            ACC_LOAD:  perm = win.r;
            default:   perm = win.w;
        endcase
        if (found) begin
            allow = perm || (mmode && !win.lock);
        end else begin
            allow = mmode;
        end
        if (allow) begin
            cause = CAUSE_NONE;
        end else begin
            unique case (kind)
                ACC_FETCH: cause = CAUSE_FETCH;
                ACC_LOAD:  cause = CAUSE_LOAD;
                default:   cause = CAUSE_STORE;
            endcase
        end
    end

endmodule

// File: rtl/pmp_unit.sv
// Module: physical memory protection unit, top level.
// Ties the register bank to one matcher per implemented entry and to the
// priority selector. Assumes PA_W = XLEN + 2 so an address register fills
// a whole control register.
module pmp_unit
    import pmp_pkg::*;
#(
    parameter int NUM_ENTRIES = 16,
    parameter int NUM_ACTIVE  = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [11:0]           csr_num,
    input  logic                  csr_we,
    input  logic [XLEN-1:0]       csr_wdata,
    output logic [XLEN-1:0]       csr_rdata,
    input  logic [PA_W-1:0]       chk_addr,
    input  logic [1:0]            chk_kind,
    input  logic                  chk_mmode,
    output logic                  chk_allow,
    output logic [CAUSE_W-1:0]    chk_cause
);

    localparam int AW = PA_W - 2;

    cfg_t [NUM_ENTRIES-1:0]         cfg_w;
    logic [NUM_ENTRIES-1:0][AW-1:0] addr_w;
    logic [NUM_ENTRIES-1:0]         hits;

    pmp_regs #(
        .NUM_ENTRIES (NUM_ENTRIES),
        .NUM_ACTIVE  (NUM_ACTIVE),
        .AW          (AW)
    ) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .csr_num   (csr_num),
        .csr_we    (csr_we),
        .csr_wdata (csr_wdata),
        .csr_rdata (csr_rdata),
        .cfg_o     (cfg_w),
        .addr_o    (addr_w)
    );

    for (genvar n = 0; n < NUM_ENTRIES; n++) begin : g_ent
        if (n < NUM_ACTIVE) begin : g_live
            logic [AW-1:0] prev;
            if (n == 0) begin : g_first
                assign prev = '0;
            end else begin : g_next
                assign prev = addr_w[n-1];
            end
            pmp_match #(.AW(AW)) match_i (
                .mode      (cfg_w[n].mode),
                .addr_cur  (addr_w[n]),
                .addr_prev (prev),
                .chk_addr  (chk_addr),
                .hit       (hits[n])
            );
        end else begin : g_tied
            assign hits[n] = 1'b0;
        end
    end

    pmp_select #(.NUM_ENTRIES(NUM_ENTRIES)) sel_i (
        .hits  (hits),
        .cfg   (cfg_w),
        .kind  (chk_kind),
        .mmode (chk_mmode),
        .allow (chk_allow),
        .cause (chk_cause)
    );

endmodule

// File: rtl/pmp_unit_chk.sv
// Module: assertion checker bound to pmp_unit.
// Assumes reset is applied before checks matter and chk_kind is never 2'b11.
module pmp_unit_chk
    import pmp_pkg::*;
#(
    parameter int NUM_ENTRIES = 16,
    parameter int NUM_ACTIVE  = 8,
    parameter int AW          = 32
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic [1:0]                     chk_kind,
    input logic                           chk_mmode,
    input logic                           chk_allow,
    input logic [CAUSE_W-1:0]             chk_cause,
    input cfg_t [NUM_ENTRIES-1:0]         cfg_w,
    input logic [NUM_ENTRIES-1:0][AW-1:0] addr_w
);

    logic all_off;

    // True when no entry has a region mode selected
    always_comb begin
        all_off = 1'b1;
        for (int n = 0; n < NUM_ENTRIES; n++) begin
            if (cfg_w[n].mode != AM_OFF) all_off = 1'b0;
        end
    end

    // R13: cause follows the kind on deny and is zero on allow
    a_r13_cause_kind: assert property (@(posedge clk) disable iff (!rst_n)
        !chk_allow |-> ((chk_kind == ACC_FETCH && chk_cause == CAUSE_FETCH) ||
                        (chk_kind == ACC_LOAD  && chk_cause == CAUSE_LOAD)  ||
                        (chk_kind == ACC_STORE && chk_cause == CAUSE_STORE)));

    a_r13_cause_zero: assert property (@(posedge clk) disable iff (!rst_n)
        chk_allow |-> chk_cause == CAUSE_NONE);

    // R8: with every entry off, only machine mode gets through
    a_r8_default: assert property (@(posedge clk) disable iff (!rst_n)
        all_off |-> (chk_allow == chk_mmode));

    for (genvar n = 0; n < NUM_ENTRIES; n++) begin : g_lk
        // R10: a locked entry keeps its byte and address
        a_r10_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(cfg_w[n].lock)) |-> $stable(cfg_w[n]));
        a_r10_addr_frozen: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(cfg_w[n].lock)) |-> $stable(addr_w[n]));
        if (n + 1 < NUM_ENTRIES) begin : g_tor
            // R11: a locked top-of-range neighbour freezes this address
            a_r11_prev_frozen: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(rst_n) && $past(cfg_w[n+1].lock) &&
                 $past(cfg_w[n+1].mode == AM_TOR)) |-> $stable(addr_w[n]));
        end
        if (n >= NUM_ACTIVE) begin : g_hw
            // R12: upper entries never leave zero
            a_r12_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
                $past(rst_n) |-> (cfg_w[n] == '0 && addr_w[n] == '0));
        end
    end

endmodule

bind pmp_unit pmp_unit_chk #(
    .NUM_ENTRIES (NUM_ENTRIES),
    .NUM_ACTIVE  (NUM_ACTIVE),
    .AW          (PA_W - 2)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .chk_kind  (chk_kind),
    .chk_mmode (chk_mmode),
    .chk_allow (chk_allow),
    .chk_cause (chk_cause),
    .cfg_w     (cfg_w),
    .addr_w    (addr_w)
);

// File: tb/pmp_unit_tb_top.sv
// Bench: directed scenarios for pmp_unit, each task checks its own results.
module pmp_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] csr_num = '0;
    logic        csr_we = 1'b0;
    logic [31:0] csr_wdata = '0;
    logic [31:0] csr_rdata;
    logic [33:0] chk_addr = '0;
    logic [1:0]  chk_kind = 2'b01;
    logic        chk_mmode = 1'b0;
    logic        chk_allow;
    logic [3:0]  chk_cause;

    int n_checks = 0;
    int n_bad = 0;

    localparam logic [1:0] K_F = 2'b00;
    localparam logic [1:0] K_L = 2'b01;
    localparam logic [1:0] K_S = 2'b10;

    always #2 clk = ~clk;

    pmp_unit dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .csr_num   (csr_num),
        .csr_we    (csr_we),
        .csr_wdata (csr_wdata),
        .csr_rdata (csr_rdata),
        .chk_addr  (chk_addr),
        .chk_kind  (chk_kind),
        .chk_mmode (chk_mmode),
        .chk_allow (chk_allow),
        .chk_cause (chk_cause)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic csr_wr(input logic [11:0] num, input logic [31:0] data);
        @(negedge clk);
        csr_num   = num;
        csr_we    = 1'b1;
        csr_wdata = data;
        @(negedge clk);
        csr_we    = 1'b0;
    endtask

    task automatic csr_rd(input string tag, input logic [11:0] num, input logic [31:0] exp);
        @(negedge clk);
        csr_we  = 1'b0;
        csr_num = num;
        #1;
        check(tag, csr_rdata, exp);
    endtask

    task automatic acc(input string tag, input logic [33:0] a, input logic [1:0] k,
                       input logic mm, input logic exp_allow, input logic [3:0] exp_cause);
        @(negedge clk);
        chk_addr  = a;
        chk_kind  = k;
        chk_mmode = mm;
        #1;
        check(tag, {27'd0, chk_allow, chk_cause}, {27'd0, exp_allow, exp_cause});
    endtask

    task automatic clear_cfg();
        csr_wr(12'h3A0, 32'h0);
        csr_wr(12'h3A1, 32'h0);
    endtask

    task automatic t_reset_state();
        csr_rd("R1 cfg0 after reset", 12'h3A0, 32'h0);
        csr_rd("R1 cfg1 after reset", 12'h3A1, 32'h0);
        csr_rd("R1 addr0 after reset", 12'h3B0, 32'h0);
        acc("R1 user fetch with all off", 34'h0, K_F, 1'b0, 1'b0, 4'd1);
    endtask

    task automatic t_no_match();
        acc("R8 machine store no match", 34'h2_0000_1234, K_S, 1'b1, 1'b1, 4'd0);
        acc("R8 user store no match", 34'h0_0000_5000, K_S, 1'b0, 1'b0, 4'd7);
        acc("R8 user load no match", 34'h0_0000_5000, K_L, 1'b0, 1'b0, 4'd5);
    endtask

    task automatic t_packing();
        csr_wr(12'h3A1, 32'h7F5E_3D6B);
        csr_rd("R2 reserved bits cleared", 12'h3A1, 32'h1F1E_1D0B);
        clear_cfg();
        csr_wr(12'h3B3, 32'hDEAD_BEEF);
        csr_rd("R3 address readback", 12'h3B3, 32'hDEAD_BEEF);
    endtask

    task automatic t_na4();
        csr_wr(12'h3B2, 32'h0000_0100);
        csr_wr(12'h3A0, 32'h0011_0000);
        acc("R5 na4 first byte", 34'h400, K_L, 1'b0, 1'b1, 4'd0);
        acc("R5 na4 last byte", 34'h403, K_L, 1'b0, 1'b1, 4'd0);
        acc("R5 na4 past end", 34'h404, K_L, 1'b0, 1'b0, 4'd5);
        acc("R9 na4 store without W", 34'h400, K_S, 1'b0, 1'b0, 4'd7);
        clear_cfg();
    endtask

    task automatic t_tor();
        csr_wr(12'h3B0, 32'h0000_0400);
        csr_wr(12'h3B1, 32'h0000_0800);
        csr_wr(12'h3A0, 32'h0000_0C0B);
        acc("R4 tor entry0 from zero", 34'h0, K_L, 1'b0, 1'b1, 4'd0);
        acc("R4 tor entry0 top word", 34'hFFC, K_L, 1'b0, 1'b1, 4'd0);
        acc("R4 tor entry1 base", 34'h1000, K_F, 1'b0, 1'b1, 4'd0);
        acc("R4 tor entry1 top word", 34'h1FFC, K_F, 1'b0, 1'b1, 4'd0);
        acc("R4 tor entry1 end excluded", 34'h2000, K_F, 1'b0, 1'b0, 4'd1);
        acc("R4 tor entry1 load no R", 34'h1000, K_L, 1'b0, 1'b0, 4'd5);
        clear_cfg();
    endtask

    task automatic t_napot();
        csr_wr(12'h3B3, 32'h0000_21FF);
        csr_wr(12'h3A0, 32'h1B00_0000);
        acc("R6 napot base", 34'h8000, K_L, 1'b0, 1'b1, 4'd0);
        acc("R6 napot last word", 34'h8FFC, K_L, 1'b0, 1'b1, 4'd0);
        acc("R6 napot middle store", 34'h8800, K_S, 1'b0, 1'b1, 4'd0);
        acc("R6 napot above", 34'h9000, K_L, 1'b0, 1'b0, 4'd5);
        acc("R6 napot below", 34'h7FFC, K_L, 1'b0, 1'b0, 4'd5);
        clear_cfg();
    endtask

    task automatic t_priority();
        csr_wr(12'h3B1, 32'h0000_1000);
        csr_wr(12'h3B2, 32'h0000_11FF);
        csr_wr(12'h3A0, 32'h001F_1000);
        acc("R7 lower entry wins", 34'h4000, K_L, 1'b0, 1'b0, 4'd5);
        acc("R7 higher entry elsewhere", 34'h4004, K_L, 1'b0, 1'b1, 4'd0);
        acc("R9 machine over unlocked", 34'h4000, K_L, 1'b1, 1'b1, 4'd0);
        clear_cfg();
    endtask

    task automatic t_hardwired();
        csr_wr(12'h3A2, 32'hFFFF_FFFF);
        csr_rd("R12 upper cfg reads zero", 12'h3A2, 32'h0);
        csr_wr(12'h3A3, 32'h1F1F_1F1F);
        csr_rd("R12 upper cfg3 reads zero", 12'h3A3, 32'h0);
        csr_wr(12'h3B8, 32'h1234_5678);
        csr_rd("R12 upper addr reads zero", 12'h3B8, 32'h0);
        csr_rd("R12 unknown number reads zero", 12'h3A4, 32'h0);
        acc("R12 upper entries never match", 34'h0, K_L, 1'b0, 1'b0, 4'd5);
    endtask

    task automatic t_lock();
        csr_wr(12'h3B4, 32'h0000_0C00);
        csr_wr(12'h3B5, 32'h0000_0C40);
        csr_wr(12'h3A1, 32'h0000_8900);
        acc("R9 locked binds machine store", 34'h3000, K_S, 1'b1, 1'b0, 4'd7);
        acc("R9 locked machine load", 34'h3000, K_L, 1'b1, 1'b1, 4'd0);
        acc("R9 locked user fetch", 34'h30FC, K_F, 1'b0, 1'b0, 4'd1);
        acc("R4 locked tor end excluded", 34'h3100, K_S, 1'b1, 1'b1, 4'd0);
        csr_wr(12'h3A1, 32'h0000_0003);
        csr_rd("R10 locked byte kept, neighbour written", 12'h3A1, 32'h0000_8903);
        csr_wr(12'h3B5, 32'h0000_1234);
        csr_rd("R10 locked address kept", 12'h3B5, 32'h0000_0C40);
        csr_wr(12'h3B4, 32'h0000_0055);
        csr_rd("R11 previous address kept", 12'h3B4, 32'h0000_0C00);
        csr_wr(12'h3B6, 32'h0000_0077);
        csr_rd("R11 unrelated address written", 12'h3B6, 32'h0000_0077);
        acc("R11 region unchanged", 34'h3000, K_S, 1'b1, 1'b0, 4'd7);
    endtask

    task automatic t_reset_clears_lock();
        do_reset();
        csr_rd("R1 lock cleared by reset", 12'h3A1, 32'h0);
        csr_rd("R1 address cleared by reset", 12'h3B4, 32'h0);
        csr_wr(12'h3B4, 32'h0000_0055);
        csr_rd("R1 address writable after reset", 12'h3B4, 32'h0000_0055);
        acc("R1 machine store after reset", 34'h3000, K_S, 1'b1, 1'b1, 4'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset_state();
        t_no_match();
        t_packing();
        t_na4();
        t_tor();
        t_napot();
        t_priority();
        t_hardwired();
        t_lock();
        t_reset_clears_lock();
        $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end

endmodule